// File: doc/BRIEF.md
# Pipelined Vertical-Crosswise 8x8 Multiplier

This block multiplies two unsigned 8-bit operands and returns the exact 16-bit product. The product is built by recursive splitting. A 2x2 leaf cell works column by column: the low column is one vertical bit product, the middle column adds two cross products, and the high column adds one vertical bit product to the carry from the middle column. Four leaf cells and a combiner form a 4x4 multiplier. Four 4x4 multipliers, one for each pairing of operand nibbles, feed a second combiner that shifts and adds their products into the 16-bit result.

Two register stages split the datapath. The first stage holds the four nibble sub-products. The second stage holds the final sum. Both stream edges use a valid/ready handshake. A transfer takes place on a rising clock edge when valid and ready are both high. When `out_ready` is low, the result register holds its value and `out_valid` stays high. A stage that holds data and cannot pass it on refuses new data. `in_ready` therefore falls only when both stages are full and the consumer is stalling. Ready propagates through the stages in the same cycle, so a full pipe accepts a new operand pair in any cycle in which the consumer takes a result. A source that sees `in_ready` low may keep its operands, change them or withdraw them. Only operands present at a transfer edge enter the pipe.

Top module: `vcm_mul8_pipe`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `out_valid` is 0, `out_product` is 0 and `in_ready` is 1.
- R2: For every accepted unsigned pair (a, b), the product delivered later equals a*b as a 16-bit value, for all 65,536 pairs.
- R3: With `out_ready` high and the pipe empty, a pair accepted at clock edge k appears with `out_valid` high after edge k+1. One cycle earlier, `out_valid` is still low.
- R4: Pairs offered on consecutive cycles are all accepted while `out_ready` is high. Results come out in acceptance order, one per cycle, with none lost or duplicated.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_product` keeps its value.
- R6: When both stages hold data and `out_ready` is low, `in_ready` is 0. A pair offered and then withdrawn during that time never produces a result.
- R7: Cycles in which `in_valid` is low produce no result. With `out_ready` high and no new input, `out_valid` is low one cycle after the last result has been taken.
- R8: Corner operands give exact results: any value times 0 is 0, 1 times x is x, and 255 times 255 is 65,025 (0xFE01).
- R9: In a cycle in which the pipe is full and the consumer takes a result, `in_ready` is 1 and the offered pair is accepted in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is offered |
| in_ready | output | 1 | Block accepts the offered pair at the next edge |
| in_a | input | 8 | Unsigned multiplicand |
| in_b | input | 8 | Unsigned multiplier |
| out_valid | output | 1 | `out_product` holds a result |
| out_ready | input | 1 | Consumer takes the result at the next edge |
| out_product | output | 16 | Unsigned product |

## Verification
Two events can fall on the same edge: the consumer takes a result from the output stage, and a new operand pair enters the first stage of a full pipe. The bench fills both stages while `out_ready` is held low. In a single cycle it then raises `out_ready` and offers a fresh pair. It expects `in_ready` to be high in that cycle. All three products must then appear in acceptance order. The same interaction occurs many times in a random run in which `out_ready` toggles while pairs stream back to back. There the ordered scoreboard catches any pair that is dropped or doubled.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  // operand width of the full multiplier
  localparam int OP_W   = 8;
  // operand width of the leaf cell
  localparam int LEAF_W = 2;
  // operand width of one sub-multiplier (nibble)
  localparam int QUAD_W = OP_W / 2;
  // product width of one sub-multiplier
  localparam int SUB_W  = 2 * QUAD_W;
  // product width of the full multiplier
  localparam int PROD_W = 2 * OP_W;
  // number of quadrants per split level
  localparam int N_QUAD = 4;

  // quadrant index: bit 1 selects the high half of a, bit 0 the high half of b
  typedef logic [N_QUAD-1:0][SUB_W-1:0] sub_set_t;
endpackage

// File: rtl/vcm_cell2.sv
module vcm_cell2
  import vcm_pkg::*;
(
  input  logic [LEAF_W-1:0]   a,
  input  logic [LEAF_W-1:0]   b,
  output logic [2*LEAF_W-1:0] p
);
  logic       col_lo;
  logic [1:0] col_mid;
  logic [1:0] col_hi;

  always_comb begin
    // low column: vertical product of the low bits, no carry in
    col_lo  = a[0] & b[0];
    // middle column: sum of both cross products
    col_mid = {1'b0, a[1] & b[0]} + {1'b0, a[0] & b[1]};
    // high column: vertical product of the high bits plus middle carry
    col_hi  = {1'b0, a[1] & b[1]} + {1'b0, col_mid[1]};
    p       = {col_hi, col_mid[0], col_lo};
  end
endmodule

// File: rtl/vcm_combine.sv
module vcm_combine #(
  parameter int HW = 2
) (
  input  logic [2*HW-1:0] hh,
  input  logic [2*HW-1:0] hl,
  input  logic [2*HW-1:0] lh,
  input  logic [2*HW-1:0] ll,
  output logic [4*HW-1:0] p
);
  localparam int SW = 2 * HW;
  localparam int PW = 4 * HW;

  logic [SW:0] cross_sum;

  always_comb begin
    // the two cross sub-products share one weight
    cross_sum = {1'b0, hl} + {1'b0, lh};
    // {hh, ll} places the two vertical sub-products without an adder
    p = {hh, ll} + (PW'(cross_sum) << HW);
  end
endmodule

// File: rtl/vcm_mul4.sv
module vcm_mul4
  import vcm_pkg::*;
(
  input  logic [QUAD_W-1:0] a,
  input  logic [QUAD_W-1:0] b,
  output logic [SUB_W-1:0]  p
);
  logic [N_QUAD-1:0][2*LEAF_W-1:0] leaf_p;

  for (genvar q = 0; q < N_QUAD; q++) begin : g_leaf
    vcm_cell2 u_cell (
      .a (a[(q/2)*LEAF_W +: LEAF_W]),
      .b (b[(q%2)*LEAF_W +: LEAF_W]),
      .p (leaf_p[q])
    );
  end

  vcm_combine #(.HW(LEAF_W)) u_join (
    .hh (leaf_p[3]),
    .hl (leaf_p[2]),
    .lh (leaf_p[1]),
    .ll (leaf_p[0]),
    .p  (p)
  );
endmodule

// File: rtl/vcm_mul8_pipe.sv
module vcm_mul8_pipe
  import vcm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_product
);
  sub_set_t          sub_now;
  sub_set_t          s1_sub;
  logic              s1_vld;
  logic              adv_out;
  logic              adv_s1;
  logic [PROD_W-1:0] sum_now;

  // four nibble sub-multipliers
  for (genvar q = 0; q < N_QUAD; q++) begin : g_quad
    vcm_mul4 u_quad (
      .a (in_a[(q/2)*QUAD_W +: QUAD_W]),
      .b (in_b[(q%2)*QUAD_W +: QUAD_W]),
      .p (sub_now[q])
    );
  end

  // stage occupancy and back-pressure (R5, R6, R9)
  always_comb begin
    adv_out  = !out_valid || out_ready;
    adv_s1   = !s1_vld || adv_out;
    in_ready = adv_s1;
  end

  // stage 1: sub-products
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
    end else if (adv_s1) begin
      s1_vld <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv_s1 && in_valid) begin
      s1_sub <= sub_now;
    end
  end

  vcm_combine #(.HW(QUAD_W)) u_final (
    .hh (s1_sub[3]),
    .hl (s1_sub[2]),
    .lh (s1_sub[1]),
    .ll (s1_sub[0]),
    .p  (sum_now)
  );

  // stage 2: final product (R1 reset clears it)
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else if (adv_out) begin
      out_valid <= s1_vld;
      if (s1_vld) begin
        out_product <= sum_now;
      end
    end
  end

  // R2
  hi_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (s1_sub[3] == SUB_W'($past(in_a[OP_W-1:QUAD_W])) * SUB_W'($past(in_b[OP_W-1:QUAD_W]))));

  // R2
  lo_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      (s1_sub[0] == SUB_W'($past(in_a[QUAD_W-1:0])) * SUB_W'($past(in_b[QUAD_W-1:0]))));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product)));

  // R3
  s1_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && out_ready) |=> out_valid);

  // R7
  empty_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!s1_vld && out_ready) |=> !out_valid);

  // R6
  refused_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready) |=> $stable(s1_sub));
endmodule

// File: tb/vcm_mul8_pipe_tb_top.sv
module vcm_mul8_pipe_tb_top;
  localparam int CLK_P   = 20;
  localparam int DRV_CHK = 2;
  localparam int MON_DLY = 6;
  localparam int WD_CYC  = 150000;

  logic        clk;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_a;
  logic [7:0]  in_b;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_product;

  int checks;
  int failures;
  int out_count;
  logic [15:0] last_out;
  logic [15:0] exp_q[$];

  vcm_mul8_pipe dut_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_product (out_product)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_P/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: records accepted pairs and compares results in order
  initial begin
    forever begin
      @(negedge clk);
      #(MON_DLY);
      if (!rst) begin
        if (in_valid && in_ready) exp_q.push_back(16'(in_a) * 16'(in_b));
        if (out_valid && out_ready) begin
          out_count++;
          last_out = out_product;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "result without accepted pair", 32'(out_product), 32'hFFFF_FFFF);
          end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(out_product == e, "R2 R4", "ordered product", 32'(out_product), 32'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog expired act=running exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic ordy);
    @(negedge clk);
    in_a      = a;
    in_b      = b;
    in_valid  = 1'b1;
    out_ready = ordy;
    #(DRV_CHK);
    while (!in_ready) begin
      @(negedge clk);
      out_ready = 1'b1;
      #(DRV_CHK);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    #(DRV_CHK);
    chk(exp_q.size() == 0, "R4", "pending results after drain", 32'(exp_q.size()), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_a = '0; in_b = '0;
    repeat (3) @(negedge clk);
    #(DRV_CHK);
    chk(!out_valid, "R1", "out_valid in reset", 32'(out_valid), 0);
    chk(out_product == 16'h0, "R1", "out_product in reset", 32'(out_product), 0);
    chk(in_ready, "R1", "in_ready in reset", 32'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #(DRV_CHK);
    chk(!out_valid && out_product == 16'h0, "R1", "state after release",
        32'({out_valid, out_product}), 0);
    chk(in_ready, "R1", "in_ready after release", 32'(in_ready), 1);
  endtask

  task automatic t_latency();
    drain();
    @(negedge clk);
    in_a = 8'd200; in_b = 8'd13; in_valid = 1'b1; out_ready = 1'b1;
    #(DRV_CHK);
    chk(in_ready, "R3", "ready on empty pipe", 32'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #(DRV_CHK);
    chk(!out_valid, "R3", "valid one edge after accept", 32'(out_valid), 0);
    @(negedge clk);
    #(DRV_CHK);
    chk(out_valid, "R3", "valid two edges after accept", 32'(out_valid), 1);
    chk(out_product == 16'd2600, "R3", "latency product", 32'(out_product), 2600);
    @(negedge clk);
    #(DRV_CHK);
    chk(!out_valid, "R7", "valid after last result taken", 32'(out_valid), 0);
  endtask

  task automatic t_corners();
    drain();
    send(8'd0, 8'd0, 1'b1);
    send(8'd0, 8'd255, 1'b1);
    send(8'd255, 8'd0, 1'b1);
    send(8'd1, 8'd255, 1'b1);
    send(8'd173, 8'd1, 1'b1);
    send(8'd15, 8'd15, 1'b1);
    send(8'd16, 8'd16, 1'b1);
    send(8'd128, 8'd2, 1'b1);
    drain();
    send(8'd255, 8'd255, 1'b1);
    drain();
    chk(last_out == 16'hFE01, "R8", "255 times 255", 32'(last_out), 32'hFE01);
    send(8'd1, 8'd199, 1'b1);
    drain();
    chk(last_out == 16'd199, "R8", "1 times x", 32'(last_out), 199);
    send(8'd91, 8'd0, 1'b1);
    drain();
    chk(last_out == 16'd0, "R8", "x times 0", 32'(last_out), 0);
  endtask

  task automatic t_bubbles();
    int cnt0;
    drain();
    cnt0 = out_count;
    for (int i = 0; i < 6; i++) begin
      send(8'(i * 40 + 3), 8'(255 - i * 7), 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
    end
    drain();
    chk(out_count - cnt0 == 6, "R7", "results per offered pair", 32'(out_count - cnt0), 6);
    chk(!out_valid, "R7", "idle output after bubbles", 32'(out_valid), 0);
  endtask

  task automatic t_backpressure();
    int cnt0;
    drain();
    cnt0 = out_count;
    send(8'd37, 8'd201, 1'b0);
    send(8'd250, 8'd99, 1'b0);
    @(negedge clk);
    in_a = 8'd77; in_b = 8'd3; in_valid = 1'b1;
    #(DRV_CHK);
    for (int i = 0; i < 4; i++) begin
      chk(!in_ready, "R6", "ready with full pipe", 32'(in_ready), 0);
      chk(out_valid, "R5", "valid held under stall", 32'(out_valid), 1);
      chk(out_product == 16'd7437, "R5", "product held under stall", 32'(out_product), 7437);
      @(negedge clk);
      #(DRV_CHK);
    end
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    chk(out_count - cnt0 == 2, "R6", "withdrawn pair produced result", 32'(out_count - cnt0), 2);
  endtask

  task automatic t_simultaneous();
    int cnt0;
    drain();
    cnt0 = out_count;
    send(8'd129, 8'd130, 1'b0);
    send(8'd66, 8'd240, 1'b0);
    @(negedge clk);
    out_ready = 1'b1;
    in_a = 8'd254; in_b = 8'd253; in_valid = 1'b1;
    #(DRV_CHK);
    chk(in_ready, "R9", "ready while result taken", 32'(in_ready), 1);
    chk(out_product == 16'd16770, "R9", "head result at release", 32'(out_product), 16770);
    @(negedge clk);
    in_valid = 1'b0;
    drain();
    chk(out_count - cnt0 == 3, "R9", "results after concurrent transfer", 32'(out_count - cnt0), 3);
  endtask

  task automatic t_random_stall();
    drain();
    for (int i = 0; i < 400; i++) begin
      send(8'($urandom), 8'($urandom), 1'($urandom));
    end
    drain();
  endtask

  task automatic t_exhaustive();
    int cnt0;
    drain();
    cnt0 = out_count;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        send(8'(a), 8'(b), 1'b1);
      end
    end
    drain();
    chk(out_count - cnt0 == 65536, "R2", "exhaustive result count", 32'(out_count - cnt0), 65536);
  endtask

  initial begin
    checks = 0; failures = 0; out_count = 0; last_out = '0;
    t_reset();
    t_latency();
    t_corners();
    t_bubbles();
    t_backpressure();
    t_simultaneous();
    t_random_stall();
    t_exhaustive();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule